// File: doc/BRIEF.md
# Variable-Length Instruction Stream Parser

This block takes machine instructions one byte per beat over a valid/ready handshake and turns each one into a single decoded record. An instruction is two, four or six bytes long. Its length is known only once its first byte, the opcode, has arrived, so the parser keeps a partly received instruction across cycles. When the last byte arrives it picks out every field the format defines and presents the record on a valid/ready output.

There are six format tags: register-register, register-storage, indexed register-storage, storage-immediate, and two storage-to-storage variants. The character variant has one long length field and the packed variant has two short ones. Storage-to-storage length fields hold the operand length minus one, and the parser reports the true operand length. A flush input drops a partly received instruction, so the upstream fetch logic can redirect the stream mid-instruction. Execution, memory access and privileged formats are outside this block.

Top module: `instr_stream_parser`

## Requirements
- R1: The two top opcode bits set the instruction length: 00 means 2 bytes, 01 or 10 means 4 bytes, and 11 means 6 bytes. A record appears only after the last byte of an instruction has been accepted, and exactly one record appears per instruction.
- R2: `out_fmt` codes are 0 register-register (top bits 00), 1 register-storage (top bits 10 with opcode bit 3 set), 2 indexed (top bits 01), 3 storage-immediate (top bits 10 with opcode bit 3 clear), 4 character storage-to-storage, and 5 packed storage-to-storage. A 64-entry map indexed by opcode bits 5:0 chooses between 4 and 5, and by default it selects packed for opcodes 0xF0 to 0xFF.
- R3: For register-register, `out_r1` is the high nibble of byte 2 and `out_r2` is its low nibble. For example, 1A 68 gives 6 and 8.
- R4: For register-storage and indexed, `out_r1` and `out_r2` are the high and low nibbles of byte 2. `out_b2` is the high nibble of byte 3. `out_d2` is the low nibble of byte 3 followed by byte 4. For example, 58 40 C1 23 gives 4, 0, 12 and 0x123.
- R5: For storage-immediate, `out_imm` is byte 2, `out_b1` is the high nibble of byte 3, and `out_d1` is the low nibble of byte 3 followed by byte 4. For example, 92 5C 36 64 gives 0x5C, 3 and 0x664.
- R6: For character storage-to-storage, `out_len1` is byte 2 plus one, in the range 1 to 256. The operand-1 base and displacement come from bytes 3-4, and the operand-2 base and displacement come from bytes 5-6.
- R7: For packed storage-to-storage, `out_len1` is the high nibble of byte 2 plus one and `out_len2` is the low nibble plus one, each in the range 1 to 16. Base and displacement fields are filled as in R6.
- R8: Every record field that the format does not define reads zero.
- R9: While `out_valid` is high and `out_ready` is low, the record holds steady and `in_ready` is low.
- R10: Reset clears `out_valid`. A `flush` cycle holds `in_ready` low and discards any partly received instruction, so the next accepted byte is taken as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Drop partial instruction |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Parser can take a byte |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Record valid |
| out_ready | input | 1 | Consumer takes record |
| out_fmt | output | 3 | Format tag (R2 codes) |
| out_opcode | output | 8 | Opcode byte |
| out_r1 | output | 4 | First register number |
| out_r2 | output | 4 | Second register, third register or index |
| out_imm | output | 8 | Immediate byte |
| out_b1 | output | 4 | Operand-1 base register |
| out_d1 | output | 12 | Operand-1 displacement |
| out_b2 | output | 4 | Operand-2 base register |
| out_d2 | output | 12 | Operand-2 displacement |
| out_len1 | output | 9 | Operand-1 length in bytes |
| out_len2 | output | 5 | Operand-2 length in bytes |

## Verification
The hardest case to reach from the ports is a flush that arrives while a six-byte instruction is half received. Nothing on the output shows that the partial bytes were there, so the only evidence of a bug is a wrong or extra record later on. The stimulus feeds three bytes of a character storage-to-storage instruction, pulses flush, and then sends a two-byte instruction. The scoreboard expects only the short record. A second case holds `out_ready` low while a record is pending, then checks that the record stays unchanged and that input is refused.

// File: rtl/isp_pkg.sv
package isp_pkg;
  localparam int BYTE_W      = 8;
  localparam int NIB_W       = BYTE_W / 2;
  localparam int DISP_W      = NIB_W + BYTE_W;
  localparam int MAX_BYTES   = 6;
  localparam int CNT_W       = $clog2(MAX_BYTES + 1);
  localparam int LONG_LEN_W  = BYTE_W + 1;
  localparam int SHORT_LEN_W = NIB_W + 1;

  typedef enum logic [2:0] {
    FMT_RR  = 3'd0,
    FMT_RS  = 3'd1,
    FMT_RX  = 3'd2,
    FMT_SI  = 3'd3,
    FMT_SSC = 3'd4,
    FMT_SSP = 3'd5
  } fmt_e;

  typedef struct packed {
    fmt_e                   fmt;
    logic [BYTE_W-1:0]      opcode;
    logic [NIB_W-1:0]       r1;
    logic [NIB_W-1:0]       r2;
    logic [BYTE_W-1:0]      imm;
    logic [NIB_W-1:0]       b1;
    logic [DISP_W-1:0]      d1;
    logic [NIB_W-1:0]       b2;
    logic [DISP_W-1:0]      d2;
    logic [LONG_LEN_W-1:0]  len1;
    logic [SHORT_LEN_W-1:0] len2;
  } rec_t;
endpackage

// File: rtl/isp_format_lookup.sv
module isp_format_lookup
  import isp_pkg::*;
#(
  parameter logic [63:0] PACKED_MAP = 64'hFFFF_0000_0000_0000
) (
  input  logic [BYTE_W-1:0] opcode,
  output fmt_e              fmt,
  output logic [CNT_W-1:0]  nbytes
);
  always_comb begin
    unique case (opcode[7:6])
      2'b00: begin
        fmt    = FMT_RR;
        nbytes = CNT_W'(2);
      end
      2'b01: begin
        fmt    = FMT_RX;
        nbytes = CNT_W'(4);
      end
      2'b10: begin
        fmt    = opcode[3] ? FMT_RS : FMT_SI;
        nbytes = CNT_W'(4);
      end
      default: begin
        fmt    = PACKED_MAP[opcode[5:0]] ? FMT_SSP : FMT_SSC;
        nbytes = CNT_W'(MAX_BYTES);
      end
    endcase
  end
endmodule

// File: rtl/isp_collector.sv
module isp_collector
  import isp_pkg::*;
#(
  parameter logic [63:0] PACKED_MAP = 64'hFFFF_0000_0000_0000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          flush,
  input  logic                          in_fire,
  input  logic [BYTE_W-1:0]             in_byte,
  output logic                          done,
  output fmt_e                          fmt_o,
  output logic [MAX_BYTES*BYTE_W-1:0]   bytes_o
);
  logic [CNT_W-1:0]  idx_q;
  logic [CNT_W-1:0]  need_q;
  fmt_e              fmt_q;
  logic [BYTE_W-1:0] buf_q [MAX_BYTES];

  fmt_e             lk_fmt;
  logic [CNT_W-1:0] lk_n;
  logic [CNT_W-1:0] cur_need;
  logic             last;

  isp_format_lookup #(.PACKED_MAP(PACKED_MAP)) u_lookup (
    .opcode (in_byte),
    .fmt    (lk_fmt),
    .nbytes (lk_n)
  );

  assign cur_need = (idx_q == '0) ? lk_n : need_q;
  assign fmt_o    = (idx_q == '0) ? lk_fmt : fmt_q;
  assign last     = (CNT_W'(idx_q + CNT_W'(1)) == cur_need);
  assign done     = in_fire && last;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      idx_q  <= '0;
      need_q <= CNT_W'(2);
      fmt_q  <= FMT_RR;
    end else if (in_fire) begin
      if (idx_q == '0) begin
        need_q <= lk_n;
        fmt_q  <= lk_fmt;
      end
      idx_q <= last ? '0 : CNT_W'(idx_q + CNT_W'(1));
    end
  end

  // byte store without reset, RAM-like
  always_ff @(posedge clk) begin
    if (in_fire) buf_q[idx_q] <= in_byte;
  end

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_asm
    assign bytes_o[g*BYTE_W +: BYTE_W] =
      (idx_q == CNT_W'(g)) ? in_byte : buf_q[g];
  end

  // R1: a partial count never reaches the length latched at the opcode
  p_idx_bound_r1: assert property (@(posedge clk) disable iff (rst)
    (idx_q != '0) |-> (idx_q < need_q));

  // R10: flush leaves the collector waiting for an opcode
  p_flush_clear_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (idx_q == '0));
endmodule

// File: rtl/isp_field_extract.sv
module isp_field_extract
  import isp_pkg::*;
(
  input  fmt_e                        fmt,
  input  logic [MAX_BYTES*BYTE_W-1:0] bytes_i,
  output rec_t                        rec
);
  logic [BYTE_W-1:0] bt [MAX_BYTES];

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_split
    assign bt[g] = bytes_i[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    rec        = '0;
    rec.fmt    = fmt;
    rec.opcode = bt[0];
    unique case (fmt)
      FMT_RR: begin
        rec.r1 = bt[1][7:4];
        rec.r2 = bt[1][3:0];
      end
      FMT_RS, FMT_RX: begin
        rec.r1 = bt[1][7:4];
        rec.r2 = bt[1][3:0];
        rec.b2 = bt[2][7:4];
        rec.d2 = {bt[2][3:0], bt[3]};
      end
      FMT_SI: begin
        rec.imm = bt[1];
        rec.b1  = bt[2][7:4];
        rec.d1  = {bt[2][3:0], bt[3]};
      end
      FMT_SSC: begin
        rec.len1 = {1'b0, bt[1]} + LONG_LEN_W'(1);
        rec.b1   = bt[2][7:4];
        rec.d1   = {bt[2][3:0], bt[3]};
        rec.b2   = bt[4][7:4];
        rec.d2   = {bt[4][3:0], bt[5]};
      end
      default: begin
        rec.len1 = LONG_LEN_W'({1'b0, bt[1][7:4]}) + LONG_LEN_W'(1);
        rec.len2 = {1'b0, bt[1][3:0]} + SHORT_LEN_W'(1);
        rec.b1   = bt[2][7:4];
        rec.d1   = {bt[2][3:0], bt[3]};
        rec.b2   = bt[4][7:4];
        rec.d2   = {bt[4][3:0], bt[5]};
      end
    endcase
  end
endmodule

// File: rtl/instr_stream_parser.sv
module instr_stream_parser
  import isp_pkg::*;
#(
  parameter logic [63:0] PACKED_MAP = 64'hFFFF_0000_0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        flush,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_byte,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [2:0]  out_fmt,
  output logic [7:0]  out_opcode,
  output logic [3:0]  out_r1,
  output logic [3:0]  out_r2,
  output logic [7:0]  out_imm,
  output logic [3:0]  out_b1,
  output logic [11:0] out_d1,
  output logic [3:0]  out_b2,
  output logic [11:0] out_d2,
  output logic [8:0]  out_len1,
  output logic [4:0]  out_len2
);
  logic                        in_fire;
  logic                        done;
  fmt_e                        col_fmt;
  logic [MAX_BYTES*BYTE_W-1:0] col_bytes;
  rec_t                        rec_d;
  rec_t                        rec_q;
  logic                        vld_q;

  assign in_ready = !flush && (!vld_q || out_ready);
  assign in_fire  = in_valid && in_ready;

  isp_collector #(.PACKED_MAP(PACKED_MAP)) u_collect (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .in_fire (in_fire),
    .in_byte (in_byte),
    .done    (done),
    .fmt_o   (col_fmt),
    .bytes_o (col_bytes)
  );

  isp_field_extract u_extract (
    .fmt     (col_fmt),
    .bytes_i (col_bytes),
    .rec     (rec_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      rec_q <= '0;
    end else if (done) begin
      vld_q <= 1'b1;
      rec_q <= rec_d;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid  = vld_q;
  assign out_fmt    = rec_q.fmt;
  assign out_opcode = rec_q.opcode;
  assign out_r1     = rec_q.r1;
  assign out_r2     = rec_q.r2;
  assign out_imm    = rec_q.imm;
  assign out_b1     = rec_q.b1;
  assign out_d1     = rec_q.d1;
  assign out_b2     = rec_q.b2;
  assign out_d2     = rec_q.d2;
  assign out_len1   = rec_q.len1;
  assign out_len2   = rec_q.len2;

  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_opcode) && $stable(out_d2) && $stable(out_len1)));

  p_flush_ready_r10: assert property (@(posedge clk) disable iff (rst)
    flush |-> !in_ready);

  p_char_len_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && rec_q.fmt == FMT_SSC) |-> (out_len1 != '0 && out_len2 == '0));

  p_packed_len_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && rec_q.fmt == FMT_SSP) |->
      (out_len1 != '0 && out_len1 <= 9'd16 && out_len2 != '0));
endmodule

// File: tb/instr_stream_parser_bench.sv
`timescale 1ns/1ps
module instr_stream_parser_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_fmt;
  logic [7:0]  out_opcode;
  logic [3:0]  out_r1, out_r2, out_b1, out_b2;
  logic [7:0]  out_imm;
  logic [11:0] out_d1, out_d2;
  logic [8:0]  out_len1;
  logic [4:0]  out_len2;

  always #2.5 clk = ~clk;

  instr_stream_parser u_instr_stream_parser (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_byte(in_byte), .out_valid(out_valid),
    .out_ready(out_ready), .out_fmt(out_fmt), .out_opcode(out_opcode),
    .out_r1(out_r1), .out_r2(out_r2), .out_imm(out_imm), .out_b1(out_b1),
    .out_d1(out_d1), .out_b2(out_b2), .out_d2(out_d2),
    .out_len1(out_len1), .out_len2(out_len2)
  );

  typedef logic [72:0] rec_v;
  rec_v expq[$];
  int   total = 0;
  int   bad = 0;
  int   cycles = 0;
  int   rdy_mode = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input rec_v act, input rec_v exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int nb_of(input logic [7:0] op);
    if (op[7:6] == 2'b00) return 2;
    if (op[7:6] == 2'b11) return 6;
    return 4;
  endfunction

  function automatic string tag_of(input logic [2:0] f);
    case (f)
      3'd0: return "R3";
      3'd1, 3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R7";
    endcase
  endfunction

  function automatic rec_v model(input logic [47:0] w);
    logic [7:0] b [6];
    logic [2:0] f;
    logic [3:0] r1, r2, b1, b2;
    logic [7:0] imm;
    logic [11:0] d1, d2;
    logic [8:0] l1;
    logic [4:0] l2;
    for (int k = 0; k < 6; k++) b[k] = w[47-8*k -: 8];
    f = 0; r1 = 0; r2 = 0; b1 = 0; b2 = 0; imm = 0; d1 = 0; d2 = 0; l1 = 0; l2 = 0;
    case (b[0][7:6])
      2'b00: begin f = 3'd0; r1 = b[1][7:4]; r2 = b[1][3:0]; end
      2'b01, 2'b10: begin
        if (b[0][7:6] == 2'b10 && !b[0][3]) begin
          f = 3'd3; imm = b[1]; b1 = b[2][7:4]; d1 = {b[2][3:0], b[3]};
        end else begin
          f = (b[0][7:6] == 2'b01) ? 3'd2 : 3'd1;
          r1 = b[1][7:4]; r2 = b[1][3:0]; b2 = b[2][7:4]; d2 = {b[2][3:0], b[3]};
        end
      end
      default: begin
        b1 = b[2][7:4]; d1 = {b[2][3:0], b[3]};
        b2 = b[4][7:4]; d2 = {b[4][3:0], b[5]};
        if (b[0][7:4] == 4'hF) begin
          f = 3'd5; l1 = 9'(b[1][7:4]) + 9'd1; l2 = 5'(b[1][3:0]) + 5'd1;
        end else begin
          f = 3'd4; l1 = 9'(b[1]) + 9'd1;
        end
      end
    endcase
    return {f, b[0], r1, r2, imm, b1, d1, b2, d2, l1, l2};
  endfunction

  // out_ready changes just after the rising edge
  always @(posedge clk) begin
    cycles++;
    #1;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = cycles[0];
      default: out_ready = 1'b0;
    endcase
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      rec_v act, exp;
      act = {out_fmt, out_opcode, out_r1, out_r2, out_imm, out_b1, out_d1,
             out_b2, out_d2, out_len1, out_len2};
      if (expq.size() == 0) begin
        check(1'b0, "R1", "unexpected record", act, '0);
      end else begin
        exp = expq.pop_front();
        check(act[72:70] == exp[72:70], "R2", "format tag", act, exp);
        check(act[69:0] == exp[69:0], {tag_of(exp[72:70]), "/R8"}, "fields", act, exp);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles == 50000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #0.5;
    in_valid = 1'b0;
  endtask

  task automatic send_range(input logic [47:0] w, input int first, input int upto);
    for (int k = first; k < upto; k++) put_byte(w[47-8*k -: 8]);
  endtask

  task automatic send(input logic [47:0] w);
    expq.push_back(model(w));
    send_range(w, 0, nb_of(w[47:40]));
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid == 1'b0, "R10", "reset out_valid", 73'(out_valid), 73'(0));
    check(in_ready == 1'b1, "R10", "reset in_ready", 73'(in_ready), 73'(1));

    // register-register and register-storage (R3, R4)
    send(48'h1A68_0000_0000);
    send(48'h07F8_0000_0000);
    send(48'h9857_7100_0000);
    send(48'h8960_000C_0000);
    // indexed (R4) and storage-immediate (R5)
    rdy_mode = 1;
    send(48'h5840_C123_0000);
    send(48'h5E47_C123_0000);
    send(48'h4770_8666_0000);
    send(48'h925C_3664_0000);
    // storage-to-storage boundaries (R6, R7)
    send(48'hD2FF_3ABC_4DEF);
    send(48'hD500_1001_2002);
    send(48'hF80F_1234_5678);
    send(48'hFAF0_9FFF_0000);
    drain();

    // R1: no record before the last byte
    rdy_mode = 0;
    expq.push_back(model(48'h5E12_3456_0000));
    send_range(48'h5E12_3456_0000, 0, 3);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "record before last byte", 73'(out_valid), 73'(0));
    send_range(48'h5E12_3456_0000, 3, 4);
    drain();

    // R9: stalled record holds and input is refused
    rdy_mode = 2;
    repeat (2) @(negedge clk);
    expq.push_back(model(48'h47A5_B6C7_0000));
    send_range(48'h47A5_B6C7_0000, 0, 4);
    repeat (2) @(negedge clk);
    #1;
    begin
      logic [11:0] snap_d2;
      logic [7:0]  snap_op;
      snap_d2 = out_d2;
      snap_op = out_opcode;
      check(out_valid == 1'b1, "R9", "stalled valid", 73'(out_valid), 73'(1));
      check(in_ready == 1'b0, "R9", "stalled in_ready", 73'(in_ready), 73'(0));
      repeat (4) @(negedge clk);
      #1;
      check(out_valid == 1'b1 && out_d2 == snap_d2 && out_opcode == snap_op,
            "R9", "record held", 73'({out_opcode, out_d2}), 73'({snap_op, snap_d2}));
    end
    rdy_mode = 0;
    drain();

    // R10: flush mid six-byte instruction, then a short one
    send_range(48'hD2FF_3ABC_4DEF, 0, 3);
    @(negedge clk);
    flush = 1'b1;
    #1;
    check(in_ready == 1'b0, "R10", "in_ready during flush", 73'(in_ready), 73'(0));
    @(negedge clk);
    flush = 1'b0;
    send(48'h1A3C_0000_0000);
    send(48'h925C_3664_0000);
    drain();
    check(expq.size() == 0, "R1", "records left over", 73'(expq.size()), 73'(0));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule